// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

The block serialises characters onto a single output line. A one-cycle write strobe places a character in a one-entry holding register. As soon as the shifter is free, the character moves into it. The shifter then sends, in order:

- a start bit of 0,
- the data bits, least significant first,
- an optional parity bit,
- one, one and a half, or two stop bits of 1.

Bit timing comes from an external baud tick, and one bit lasts 16 ticks. Configuration inputs choose the word length, the stop-bit length and the parity mode. A separate break input pulls the line low.

The frame format is captured when a character enters the shifter. A running frame is therefore never disturbed by configuration changes. Two status outputs tell the feeding logic when another character can be written, and when the line has fully drained.

Top module: `uartTxTop`

## Requirements
- R1: After reset the line output is 1, and both the holding-empty and transmitter-empty outputs are 1.
- R2: A frame begins with a start bit of 0, followed by the data bits least significant first. Every start, data and parity bit lasts 16 baud ticks. The word length code 00, 01, 10, 11 selects 5, 6, 7, 8 data bits, and upper data bits are not sent.
- R3: With stopSel at 0 the stop bit (1) lasts 16 ticks. With stopSel at 1 it lasts 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words.
- R4: The parity bit is chosen by three inputs:
  - parityOn at 0: no parity bit is sent.
  - parityOn 1, parityStick 0, parityEven 0: the bit makes the count of ones in data plus parity odd.
  - parityOn 1, parityStick 0, parityEven 1: the bit makes that count even.
  - parityOn 1, parityStick 1, parityEven 0: the bit is forced to 1.
  - parityOn 1, parityStick 1, parityEven 1: the bit is forced to 0.
- R5: While breakOn is 1, the line output is 0 in the same cycle, whether the transmitter is idle or busy. Frame timing continues underneath. Clearing breakOn restores the normal line level in the same cycle.
- R6: A write makes holding-empty 0 after that clock edge. The character moves to the shifter at the next edge where the shifter is idle, or at the edge of the last tick of a stop bit. Holding-empty returns to 1 at that same edge, unless a new write arrives in that cycle.
- R7: Transmitter-empty is 1 only when the holding register is empty and no frame is in progress. While either holds a character it is 0.
- R8: A character waiting in the holding register starts its start bit directly after the last stop tick of the previous frame, with no idle time on the line.
- R9: Word length, stop length and parity settings are sampled when a character enters the shifter. Changes made during a frame take effect from the next frame.
- R10: A write while the holding register is full replaces the waiting character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse, 16 per bit time |
| wrStrobe | input | 1 | Load wrData into the holding register |
| wrData | input | 8 | Character to send |
| wordLen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| stopSel | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| parityOn | input | 1 | Send a parity bit |
| parityEven | input | 1 | Even parity, or forced 0 with stick |
| parityStick | input | 1 | Force the parity bit to a fixed level |
| breakOn | input | 1 | Hold the line at 0 |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
Each result is due at a known point:

- holdEmpty falls one edge after the write.
- The start bit and the return of holdEmpty appear one edge later, when the shifter is idle.
- Each line bit changes on the edge that consumes the sixteenth tick of that bit (the 24th or 32nd tick for a stop bit).
- The break override acts in the same cycle.

The bench drives every input on the falling clock edge and spaces each tick with an idle cycle. It compares the line against a frame computed from the requirements before every single tick, so a bit that is one tick short or long fails at that exact tick. Checks for the break override are taken a fraction of a cycle after the input changes, with no clock edge in between.

// File: rtl/uartTxPkg.sv
package uartTxPkg;

  localparam int DATA_W = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadShift;
    logic     shiftNext;
    txState_t sel;
  } txStrobe_t;

  // frame format captured with each character
  typedef struct packed {
    logic [1:0] wordLen;
    logic       stopSel;
    logic       parityOn;
  } frameCfg_t;

endpackage

// File: rtl/uartTxDatapath.sv
module uartTxDatapath
  import uartTxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wordLen,
  input  logic              stopSel,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              parityStick,
  input  logic              breakOn,
  input  txStrobe_t         strobe,
  output frameCfg_t         frameCfg,
  output logic              txOut
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] maskedData;
  logic              parityReg;
  logic              parityCalc;
  logic              onesOdd;
  logic              lineLevel;

  // only the selected word length takes part in parity
  for (genvar i = 0; i < DATA_W; i++) begin : gMask
    assign maskedData[i] = holdData[i] & (i < MIN_BITS + int'(wordLen));
  end

  assign onesOdd    = ^maskedData;
  assign parityCalc = parityStick ? ~parityEven
                                  : (parityEven ? onesOdd : ~onesOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
    end else if (wrStrobe) begin
      holdData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityReg <= 1'b0;
      frameCfg  <= '{wordLen: 2'b11, stopSel: 1'b0, parityOn: 1'b0};
    end else if (strobe.loadShift) begin
      shiftReg  <= holdData;
      parityReg <= parityCalc;
      frameCfg  <= '{wordLen: wordLen, stopSel: stopSel, parityOn: parityOn};
    end else if (strobe.shiftNext) begin
      shiftReg  <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.sel)
      ST_START:  lineLevel = 1'b0;
      ST_DATA:   lineLevel = shiftReg[0];
      ST_PARITY: lineLevel = parityReg;
      default:   lineLevel = 1'b1;
    endcase
  end

  assign txOut = breakOn ? 1'b0 : lineLevel;

endmodule

// File: rtl/uartTxControl.sv
module uartTxControl
  import uartTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      wrStrobe,
  input  frameCfg_t frameCfg,
  output txStrobe_t strobe,
  output logic      holdEmpty,
  output logic      txEmpty
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST_BIT    = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_HALF   = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_DOUBLE = CNT_W'(2 * TICKS_PER_BIT - 1);

  txState_t         state, stateNext;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [2:0]       bitIdx, idxNext;
  logic [2:0]       nBitsLast;
  logic [CNT_W-1:0] stopLast;
  logic [CNT_W-1:0] curLast;
  logic             holdValid;
  logic             bitEnd;
  logic             stopEnd;
  logic             loadShift;
  logic             shiftNext;

  assign nBitsLast = 3'd4 + {1'b0, frameCfg.wordLen};
  assign stopLast  = !frameCfg.stopSel         ? LAST_BIT :
                     (frameCfg.wordLen == 2'b00) ? LAST_HALF : LAST_DOUBLE;
  assign curLast   = (state == ST_STOP) ? stopLast : LAST_BIT;
  assign bitEnd    = baudTick && (tickCnt == curLast);
  assign stopEnd   = (state == ST_STOP) && bitEnd;
  assign loadShift = holdValid && ((state == ST_IDLE) || stopEnd);

  always_comb begin
    stateNext = state;
    cntNext   = tickCnt;
    idxNext   = bitIdx;
    shiftNext = 1'b0;
    if (baudTick && state != ST_IDLE) cntNext = tickCnt + 1'b1;
    case (state)
      ST_IDLE: begin
        if (loadShift) begin
          stateNext = ST_START;
          cntNext   = '0;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          stateNext = ST_DATA;
          cntNext   = '0;
          idxNext   = '0;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          shiftNext = 1'b1;
          cntNext   = '0;
          if (bitIdx == nBitsLast) begin
            stateNext = frameCfg.parityOn ? ST_PARITY : ST_STOP;
          end else begin
            idxNext = bitIdx + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bitEnd) begin
          stateNext = ST_STOP;
          cntNext   = '0;
        end
      end
      ST_STOP: begin
        if (bitEnd) begin
          cntNext   = '0;
          stateNext = loadShift ? ST_START : ST_IDLE;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      holdValid <= 1'b0;
    end else begin
      state   <= stateNext;
      tickCnt <= cntNext;
      bitIdx  <= idxNext;
      if (wrStrobe)       holdValid <= 1'b1;
      else if (loadShift) holdValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadShift = loadShift;
    strobe.shiftNext = shiftNext;
    strobe.sel       = state;
  end

  assign holdEmpty = !holdValid;
  assign txEmpty   = !holdValid && (state == ST_IDLE);

  AST_LOAD_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    loadShift |=> (state == ST_START && tickCnt == '0)); // R8

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (loadShift && !wrStrobe) |=> holdEmpty); // R6

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_STOP) |-> (tickCnt <= LAST_BIT)); // R2

  AST_DATA_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx <= nBitsLast)); // R2

endmodule

// File: rtl/uartTxTop.sv
module uartTxTop
  import uartTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wordLen,
  input  logic              stopSel,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              parityStick,
  input  logic              breakOn,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              txEmpty
);

  txStrobe_t strobe;
  frameCfg_t frameCfg;

  uartTxControl #(.TICKS_PER_BIT(TICKS_PER_BIT)) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .wrStrobe  (wrStrobe),
    .frameCfg  (frameCfg),
    .strobe    (strobe),
    .holdEmpty (holdEmpty),
    .txEmpty   (txEmpty)
  );

  uartTxDatapath uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .wrStrobe    (wrStrobe),
    .wrData      (wrData),
    .wordLen     (wordLen),
    .stopSel     (stopSel),
    .parityOn    (parityOn),
    .parityEven  (parityEven),
    .parityStick (parityStick),
    .breakOn     (breakOn),
    .strobe      (strobe),
    .frameCfg    (frameCfg),
    .txOut       (txOut)
  );

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakOn) |-> txOut); // R7

endmodule

// File: tb/tb_uartTxTop.sv
`timescale 1ns/1ps
module tb_uartTxTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] wordLen = 2'b11;
  logic       stopSel = 1'b0;
  logic       parityOn = 1'b0;
  logic       parityEven = 1'b0;
  logic       parityStick = 1'b0;
  logic       breakOn = 1'b0;
  logic       txOut, holdEmpty, txEmpty;

  int checks = 0;
  int failures = 0;
  int expBit [16];
  int expLen [16];
  int nExp = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uartTxTop dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrStrobe(wrStrobe),
    .wrData(wrData), .wordLen(wordLen), .stopSel(stopSel),
    .parityOn(parityOn), .parityEven(parityEven), .parityStick(parityStick),
    .breakOn(breakOn), .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  task automatic chk(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] wl, input logic ss, input logic po,
                        input logic pe, input logic ps);
    wordLen = wl; stopSel = ss; parityOn = po; parityEven = pe; parityStick = ps;
  endtask

  task automatic tickOnce();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] d);
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  // expected frame from the requirements (R2, R3, R4)
  task automatic buildFrame(input logic [7:0] d, input int wl, input bit ss,
                            input bit po, input bit pe, input bit ps);
    int n = 5 + wl;
    int ones = 0;
    nExp = 0;
    expBit[nExp] = 0; expLen[nExp] = 16; nExp++;
    for (int i = 0; i < n; i++) begin
      expBit[nExp] = d[i]; expLen[nExp] = 16; nExp++;
      ones += d[i];
    end
    if (po) begin
      if (ps) expBit[nExp] = pe ? 0 : 1;
      else    expBit[nExp] = pe ? (ones % 2) : ((ones + 1) % 2);
      expLen[nExp] = 16; nExp++;
    end
    expBit[nExp] = 1;
    expLen[nExp] = !ss ? 16 : ((wl == 0) ? 24 : 32);
    nExp++;
  endtask

  task automatic runFrame(input string req);
    for (int b = 0; b < nExp; b++) begin
      for (int t = 0; t < expLen[b]; t++) begin
        chk(txOut, expBit[b], req, $sformatf("bit %0d tick %0d", b, t));
        tickOnce();
      end
    end
  endtask

  task automatic testReset();
    chk(txOut, 1, "R1", "line after reset");
    chk(holdEmpty, 1, "R1", "holdEmpty after reset");
    chk(txEmpty, 1, "R1", "txEmpty after reset");
  endtask

  task automatic testBasic();
    setCfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    writeChar(8'hA5);
    chk(holdEmpty, 0, "R6", "holdEmpty after write");
    chk(txEmpty, 0, "R7", "txEmpty after write");
    @(negedge clk);
    chk(holdEmpty, 1, "R6", "holdEmpty after transfer");
    chk(txEmpty, 0, "R7", "txEmpty while shifting");
    buildFrame(8'hA5, 3, 0, 0, 0, 0);
    runFrame("R2");
    chk(txOut, 1, "R1", "idle line after frame");
    chk(txEmpty, 1, "R7", "txEmpty after frame");
  endtask

  task automatic sendOne(input logic [7:0] d, input int wl, input bit ss, input bit po,
                         input bit pe, input bit ps, input string req);
    setCfg(2'(wl), ss, po, pe, ps);
    writeChar(d);
    @(negedge clk);
    buildFrame(d, wl, ss, po, pe, ps);
    runFrame(req);
    chk(txEmpty, 1, req, "txEmpty after frame");
  endtask

  task automatic testFormats();
    sendOne(8'hFB, 0, 1, 1, 1, 0, "R3");  // 5-bit, 1.5 stop, even
    sendOne(8'h53, 2, 1, 1, 0, 0, "R4");  // 7-bit, 2 stop, odd
    sendOne(8'h2A, 1, 0, 1, 0, 1, "R4");  // 6-bit, forced 1
    sendOne(8'hFF, 3, 0, 1, 1, 1, "R4");  // 8-bit, forced 0
    sendOne(8'h96, 3, 1, 0, 0, 0, "R3");  // 8-bit, 2 stop
  endtask

  task automatic testBackToBack();
    setCfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    writeChar(8'h11);
    @(negedge clk);
    writeChar(8'h22);
    writeChar(8'h33);
    chk(holdEmpty, 0, "R10", "holdEmpty with pending char");
    chk(txEmpty, 0, "R7", "txEmpty with both full");
    buildFrame(8'h11, 3, 0, 0, 0, 0);
    runFrame("R8");
    chk(holdEmpty, 1, "R6", "holdEmpty at chained transfer");
    buildFrame(8'h33, 3, 0, 0, 0, 0);
    runFrame("R10");
    chk(txEmpty, 1, "R8", "txEmpty after chained frames");
  endtask

  task automatic testCfgLatch();
    setCfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    writeChar(8'h5A);
    @(negedge clk);
    setCfg(2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    buildFrame(8'h5A, 3, 0, 0, 0, 0);
    runFrame("R9");
    writeChar(8'h5A);
    @(negedge clk);
    buildFrame(8'h5A, 0, 1, 1, 1, 0);
    runFrame("R9");
    chk(txEmpty, 1, "R9", "txEmpty after second frame");
  endtask

  task automatic testBreak();
    setCfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    breakOn = 1'b1;
    #1;
    chk(txOut, 0, "R5", "break while idle");
    @(negedge clk);
    writeChar(8'h0F);
    @(negedge clk);
    buildFrame(8'h0F, 3, 0, 0, 0, 0);
    for (int b = 0; b < nExp; b++) expBit[b] = 0;
    runFrame("R5");
    chk(txEmpty, 1, "R5", "frame timing kept under break");
    chk(txOut, 0, "R5", "break still holds line");
    breakOn = 1'b0;
    #1;
    chk(txOut, 1, "R5", "line after break cleared");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testFormats();
    testBackToBack();
    testCfgLatch();
    testBreak();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule